// File: doc/BRIEF.md
# Serial Memory Slave Command Front End

This block is the serial slave side of a 512-byte nonvolatile memory model. It sits between a four-wire serial bus (clock, data in, data out, active-low select) plus an active-low pause pin, and the blocks that hold the array, apply write protection and time the programming cycle. All bus pins are oversampled by the system clock. Bits are taken in on rising serial clock edges, most significant bit first. The block assembles an opcode, takes the ninth address bit from opcode bit 3, and collects the lower address byte. It then either streams read data out on falling edges or hands each received write byte to the array side.

Everything the block decodes is reported as a single-cycle pulse: array fetch, write byte with its address, write-enable set or clear, status read, status write and select release. The pause pin freezes a transaction in mid-bit and releases it again. Entry to and exit from the pause are allowed only while the serial clock is low. Array reads are refused while the array side signals a programming cycle, but status reads are always served.

Top module: `spi_mem_frontend`

## Requirements
- R1: Input bits are taken on rising serial clock edges, MSB first. The opcode forms are 0000_A011 (read) and 0000_A010 (write), with A giving address bit 8 and the following byte giving address bits 7..0.
- R2: Read data leaves MSB first and changes only after falling edges. The first data bit is driven after the falling edge that follows the last address bit.
- R3: During a read the address advances by one after each byte, and 0x1FF is followed by 0x000.
- R4: In a write, each completed data byte pulses `wr_byte_o` with `wr_addr_o` and `wr_data_o`. The address advances inside its 16-byte page, so 0x13F is followed by 0x130.
- R5: Opcode 0x06 pulses `wren_o` and opcode 0x04 pulses `wrdi_o`. Either pulse is given only when select rises after exactly 8 bits.
- R6: Opcode 0x05 returns `status_i` byte after byte for as long as clocks continue, even while `busy_i` is high. Opcode 0x01 pulses `wrsr_o` with the next byte on `wr_data_o`.
- R7: `miso_oe_o` is low whenever select is high. After reset, no transaction starts until select has been seen high and then low.
- R8: The pause state is entered or left only while the sampled serial clock is low. While paused, clock and data transitions are ignored, and on release the transaction continues from the same bit.
- R9: A low pause pin forces `miso_oe_o` low on the next system cycle, whatever the clock level.
- R10: A read whose address byte completes while `busy_i` is high drives no data: `miso_oe_o` stays low until select rises.
- R11: Any other opcode makes the block ignore input until select rises. Every select fall restarts the bit count.
- R12: A rise of select ending a transaction pulses `cs_rise_o`, with `cs_aligned_o` high when a whole number of bytes was clocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock pin |
| mosi_i | input | 1 | Serial data input pin |
| cs_n_i | input | 1 | Active-low select pin |
| hold_n_i | input | 1 | Active-low pause pin |
| busy_i | input | 1 | Programming cycle in progress on the array side |
| status_i | input | 8 | Status byte returned by a status read |
| rd_data_i | input | 8 | Array byte at `rd_addr_o`, one system cycle behind |
| rd_addr_o | output | 9 | Current access address |
| rd_fetch_o | output | 1 | Pulse: a new read address has been presented |
| wr_byte_o | output | 1 | Pulse: a write data byte is complete |
| wr_addr_o | output | 9 | Address of the reported write byte |
| wr_data_o | output | 8 | Write byte or status write byte |
| wren_o | output | 1 | Pulse: write-enable set request |
| wrdi_o | output | 1 | Pulse: write-enable clear request |
| rdsr_o | output | 1 | Pulse: status read opcode decoded |
| wrsr_o | output | 1 | Pulse: status write byte received |
| cs_rise_o | output | 1 | Pulse: select released at the end of a transaction |
| cs_aligned_o | output | 1 | Whole-byte flag, valid with `cs_rise_o` |
| miso_o | output | 1 | Serial data output value |
| miso_oe_o | output | 1 | Output enable for `miso_o` |

## Verification
Sequential reads start at addresses chosen so that a wrong bit-8 extraction, a missing wrap at 0x1FF or an off-by-one first bit each give different bytes. A page-crossing write shows whether the page index is kept apart from the full address. Transactions cut one bit long or short, an opcode-free select pulse, and select held low through reset separate byte alignment from plain decoding. Pauses placed mid-read and mid-write, with clock toggles and data noise during the pause, and a short pause pulse inside a clock-high phase separate correct freezing from corruption or lost bits.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W + 1;

  localparam logic [BYTE_W-1:0] OPC_SET_WE = 8'h06;
  localparam logic [BYTE_W-1:0] OPC_CLR_WE = 8'h04;
  localparam logic [BYTE_W-1:0] OPC_STAT_RD = 8'h05;
  localparam logic [BYTE_W-1:0] OPC_STAT_WR = 8'h01;
  localparam logic [2:0] OPC_LOW_READ = 3'b011;
  localparam logic [2:0] OPC_LOW_WRITE = 3'b010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADR, ST_RD, ST_WR, ST_STAT, ST_WSR, ST_SINK
  } fe_state_t;

  typedef enum logic [1:0] {
    PEND_NONE, PEND_SET, PEND_CLR
  } fe_pend_t;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], din[b]};
      end
      assign dout[b] = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic sck_lvl,
  input  logic hold_n_lvl,
  output logic paused
);
  always_ff @(posedge clk) begin
    if (rst || !active) paused <= 1'b0;
    else if (!sck_lvl)  paused <= !hold_n_lvl;
  end

  assert_pause_enter_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(paused) |-> $past(!sck_lvl));
  assert_pause_leave_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(paused) && active) |-> $past(!sck_lvl && hold_n_lvl));
endmodule

// File: rtl/spi_fe_engine.sv
module spi_fe_engine
  import spi_fe_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_lvl,
  input  logic              cs_n_lvl,
  input  logic              mosi_lvl,
  input  logic              hold_n_lvl,
  input  logic              paused,
  input  logic              busy,
  input  logic [BYTE_W-1:0] status,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              in_txn_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_fetch_o,
  output logic              wr_byte_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wren_o,
  output logic              wrdi_o,
  output logic              rdsr_o,
  output logic              wrsr_o,
  output logic              cs_rise_o,
  output logic              cs_aligned_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam int PAGE_HI = ADDR_W - 1;
  localparam logic [PAGE_W-1:0] PAGE_ONE = 1;

  fe_state_t         state;
  fe_pend_t          pend;
  logic [2:0]        bitcnt, ocnt;
  logic [6:0]        shreg;
  logic [BYTE_W-1:0] oreg;
  logic [ADDR_W-1:0] addr;
  logic              a8, is_read, driving, armed, in_txn;
  logic              sck_q, cs_q;

  wire sck_rise = sck_lvl & ~sck_q;
  wire sck_fall = ~sck_lvl & sck_q;
  wire cs_fall  = ~cs_n_lvl & cs_q;
  wire cs_rise  = cs_n_lvl & ~cs_q;
  wire go_rise  = sck_rise & in_txn & ~paused;
  wire go_fall  = sck_fall & in_txn & ~paused;
  wire [BYTE_W-1:0] in_byte = {shreg, mosi_lvl};
  wire out_state = (state == ST_RD) || (state == ST_STAT);

  assign in_txn_o = in_txn;
  assign addr_o   = addr;
  assign miso_o   = oreg[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; pend <= PEND_NONE;
      bitcnt <= '0; ocnt <= '0; shreg <= '0; oreg <= '0; addr <= '0;
      a8 <= 1'b0; is_read <= 1'b0; driving <= 1'b0; armed <= 1'b0;
      in_txn <= 1'b0; sck_q <= 1'b0; cs_q <= 1'b0;
      rd_fetch_o <= 1'b0; wr_byte_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
      wren_o <= 1'b0; wrdi_o <= 1'b0; rdsr_o <= 1'b0; wrsr_o <= 1'b0;
      cs_rise_o <= 1'b0; cs_aligned_o <= 1'b0; miso_oe_o <= 1'b0;
    end else begin
      rd_fetch_o <= 1'b0; wr_byte_o <= 1'b0; wren_o <= 1'b0; wrdi_o <= 1'b0;
      rdsr_o <= 1'b0; wrsr_o <= 1'b0; cs_rise_o <= 1'b0;
      sck_q <= sck_lvl;
      cs_q  <= cs_n_lvl;
      if (cs_n_lvl) armed <= 1'b1;
      miso_oe_o <= in_txn & ~cs_n_lvl & hold_n_lvl & ~paused & driving & out_state;

      if (cs_fall && armed) begin
        in_txn <= 1'b1; state <= ST_OPC; pend <= PEND_NONE;
        bitcnt <= '0; ocnt <= '0; driving <= 1'b0; oreg <= '0;
      end else if (cs_rise && in_txn) begin
        in_txn <= 1'b0; state <= ST_IDLE; driving <= 1'b0;
        cs_rise_o <= 1'b1;
        cs_aligned_o <= (bitcnt == 3'd0);
        if (bitcnt == 3'd0 && pend == PEND_SET) wren_o <= 1'b1;
        if (bitcnt == 3'd0 && pend == PEND_CLR) wrdi_o <= 1'b1;
        pend <= PEND_NONE;
      end else if (go_rise) begin
        bitcnt <= bitcnt + 3'd1;
        shreg  <= {shreg[5:0], mosi_lvl};
        pend   <= PEND_NONE;
        if (bitcnt == 3'd7) begin
          case (state)
            ST_OPC: begin
              if (in_byte[7:4] == 4'h0 && in_byte[2:0] == OPC_LOW_READ) begin
                a8 <= in_byte[3]; is_read <= 1'b1; state <= ST_ADR;
              end else if (in_byte[7:4] == 4'h0 && in_byte[2:0] == OPC_LOW_WRITE) begin
                a8 <= in_byte[3]; is_read <= 1'b0; state <= ST_ADR;
              end else if (in_byte == OPC_SET_WE) begin
                pend <= PEND_SET; state <= ST_SINK;
              end else if (in_byte == OPC_CLR_WE) begin
                pend <= PEND_CLR; state <= ST_SINK;
              end else if (in_byte == OPC_STAT_RD) begin
                rdsr_o <= 1'b1; state <= ST_STAT; ocnt <= '0;
              end else if (in_byte == OPC_STAT_WR) begin
                state <= ST_WSR;
              end else begin
                state <= ST_SINK;
              end
            end
            ST_ADR: begin
              addr <= {a8, in_byte};
              if (!is_read)   state <= ST_WR;
              else if (busy)  state <= ST_SINK;
              else begin
                state <= ST_RD; ocnt <= '0; rd_fetch_o <= 1'b1;
              end
            end
            ST_WR: begin
              wr_byte_o <= 1'b1;
              wr_addr_o <= addr;
              wr_data_o <= in_byte;
              addr <= {addr[PAGE_HI:PAGE_W], addr[PAGE_W-1:0] + PAGE_ONE};
            end
            ST_WSR: begin
              wrsr_o <= 1'b1; wr_data_o <= in_byte; state <= ST_SINK;
            end
            default: ;
          endcase
        end
      end else if (go_fall && out_state) begin
        ocnt <= ocnt + 3'd1;
        if (ocnt == 3'd0) begin
          oreg <= (state == ST_RD) ? rd_data : status;
          driving <= 1'b1;
          if (state == ST_RD) begin
            addr <= addr + 9'd1;
            rd_fetch_o <= 1'b1;
          end
        end else begin
          oreg <= {oreg[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assert_oe_deselect_R7: assert property (@(posedge clk) disable iff (rst)
    cs_n_lvl |=> !miso_oe_o);
  assert_hold_tristate_R9: assert property (@(posedge clk) disable iff (rst)
    !hold_n_lvl |=> !miso_oe_o);
  assert_event_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wren_o, wrdi_o, wr_byte_o, wrsr_o}));
  assert_we_on_release_R5: assert property (@(posedge clk) disable iff (rst)
    (wren_o || wrdi_o) |-> (cs_rise_o && cs_aligned_o));
  assert_page_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR && $past(state) == ST_WR) |-> addr[PAGE_HI:PAGE_W] == $past(addr[PAGE_HI:PAGE_W]));
  assert_busy_block_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD && $past(state) == ST_ADR) |-> !$past(busy));
  assert_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (paused && !cs_fall && !cs_rise) |=> ($stable(bitcnt) && $stable(oreg)));
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_fe_pkg::*;
#(
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              cs_n_i,
  input  logic              hold_n_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_fetch_o,
  output logic              wr_byte_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wren_o,
  output logic              wrdi_o,
  output logic              rdsr_o,
  output logic              wrsr_o,
  output logic              cs_rise_o,
  output logic              cs_aligned_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam int NPINS = 4;

  logic [NPINS-1:0] pins_sync;
  logic             paused, in_txn;

  spi_fe_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .din({hold_n_i, mosi_i, cs_n_i, sck_i}),
    .dout(pins_sync)
  );

  spi_fe_hold u_hold (
    .clk(clk), .rst(rst), .active(in_txn),
    .sck_lvl(pins_sync[0]), .hold_n_lvl(pins_sync[3]), .paused(paused)
  );

  spi_fe_engine #(.PAGE_W(PAGE_W)) u_eng (
    .clk(clk), .rst(rst),
    .sck_lvl(pins_sync[0]), .cs_n_lvl(pins_sync[1]),
    .mosi_lvl(pins_sync[2]), .hold_n_lvl(pins_sync[3]),
    .paused(paused), .busy(busy_i), .status(status_i), .rd_data(rd_data_i),
    .in_txn_o(in_txn), .addr_o(rd_addr_o), .rd_fetch_o(rd_fetch_o),
    .wr_byte_o(wr_byte_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wren_o(wren_o), .wrdi_o(wrdi_o), .rdsr_o(rdsr_o), .wrsr_o(wrsr_o),
    .cs_rise_o(cs_rise_o), .cs_aligned_o(cs_aligned_o),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o)
  );
endmodule

// File: tb/spi_mem_frontend_test.sv
`timescale 1ns/1ps
module spi_mem_frontend_test;
  localparam int HALF = 100;

  logic clk = 0, rst = 1;
  logic sck = 0, mosi = 0, cs_n = 0, hold_n = 1, busy = 0;
  logic [7:0] status = 8'h00, rd_data = 8'h00;
  logic [8:0] rd_addr, wr_addr;
  logic [7:0] wr_data;
  logic rd_fetch, wr_byte, wren, wrdi, rdsr, wrsr, cs_rise, cs_aligned, miso, miso_oe;

  int compared = 0, mismatched = 0;
  int n_wren = 0, n_wrdi = 0, n_rdsr = 0, n_wrsr = 0, n_wr = 0, n_csr = 0;
  logic last_aligned = 0;
  logic [7:0] last_wrsr = 0;
  logic [8:0] cap_a [16];
  logic [7:0] cap_d [16];
  logic oe_any = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_mem_frontend uut (
    .clk(clk), .rst(rst), .sck_i(sck), .mosi_i(mosi), .cs_n_i(cs_n), .hold_n_i(hold_n),
    .busy_i(busy), .status_i(status), .rd_data_i(rd_data),
    .rd_addr_o(rd_addr), .rd_fetch_o(rd_fetch), .wr_byte_o(wr_byte), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wren_o(wren), .wrdi_o(wrdi), .rdsr_o(rdsr), .wrsr_o(wrsr),
    .cs_rise_o(cs_rise), .cs_aligned_o(cs_aligned), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  function automatic logic [7:0] memval(input logic [8:0] a);
    return a[7:0] ^ {a[8], 7'h35} ^ {a[3:0], a[7:4]};
  endfunction

  always @(posedge clk) begin
    rd_data <= memval(rd_addr);
    if (wren) n_wren++;
    if (wrdi) n_wrdi++;
    if (rdsr) n_rdsr++;
    if (wrsr) begin n_wrsr++; last_wrsr = wr_data; end
    if (cs_rise) begin n_csr++; last_aligned = cs_aligned; end
    if (wr_byte) begin
      if (n_wr < 16) begin cap_a[n_wr] = wr_addr; cap_d[n_wr] = wr_data; end
      n_wr++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    mosi = b;
    #HALF;
    r = miso;
    oe_any = oe_any | miso_oe;
    sck = 1;
    #HALF;
    sck = 0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      bit_xfer(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic begin_txn();
    cs_n = 0;
    #HALF;
  endtask

  task automatic end_txn();
    #HALF;
    cs_n = 1;
    #(4*HALF);
  endtask

  localparam logic [13:0] RD_VEC [5] = '{
    {9'h000, 5'd3}, {9'h1FE, 5'd4}, {9'h0FF, 5'd2}, {9'h15A, 5'd2}, {9'h1FF, 5'd1}
  };

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    logic r;
    logic [7:0] got;
    int base_wren, base_wr;
    repeat (6) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R7 reset oe", miso_oe, 0);
    chk("R7 reset events", n_wren + n_wrdi + n_csr + n_wr, 0);
    // select held low since reset: no transaction may start
    xfer(8'h06, rx);
    end_txn();
    chk("R7 no txn before select high", n_wren, 0);
    chk("R12 no release event without txn", n_csr, 0);

    // table of sequential reads
    for (int v = 0; v < 5; v++) begin
      logic [8:0] a;
      int n;
      a = RD_VEC[v][13:5];
      n = int'(RD_VEC[v][4:0]);
      begin_txn();
      xfer({4'h0, a[8], 3'b011}, rx);
      xfer(a[7:0], rx);
      for (int k = 0; k < n; k++) begin
        logic [8:0] ea;
        ea = a + 9'(k);
        xfer(8'hFF, rx);
        chk("R1/R2/R3 read byte", rx, memval(ea));
      end
      end_txn();
      chk("R7 oe after release", miso_oe, 0);
    end

    // write-enable set, aligned
    begin_txn(); xfer(8'h06, rx); end_txn();
    chk("R5 wren pulse", n_wren, 1);
    chk("R12 aligned flag", last_aligned, 1);
    // one extra bit
    begin_txn(); xfer(8'h06, rx); bit_xfer(1'b0, r); end_txn();
    chk("R5 wren needs 8 bits", n_wren, 1);
    chk("R12 unaligned flag", last_aligned, 0);
    // write-enable clear
    begin_txn(); xfer(8'h04, rx); end_txn();
    chk("R5 wrdi pulse", n_wrdi, 1);
    // partial then full: bit counter restarts
    begin_txn(); bit_xfer(1'b1, r); bit_xfer(1'b0, r); bit_xfer(1'b1, r); end_txn();
    begin_txn(); xfer(8'h04, rx); end_txn();
    chk("R11 count restarts on select", n_wrdi, 2);

    // status read during busy, repeated
    status = 8'hA5; busy = 1;
    begin_txn(); xfer(8'h05, rx);
    xfer(8'h00, rx); chk("R6 status byte 1", rx, 8'hA5);
    xfer(8'h00, rx); chk("R6 status byte 2", rx, 8'hA5);
    end_txn();
    chk("R6 status read event", n_rdsr, 1);
    busy = 0;
    begin_txn(); xfer(8'h01, rx); xfer(8'h0C, rx); end_txn();
    chk("R6 status write event", n_wrsr, 1);
    chk("R6 status write data", last_wrsr, 8'h0C);

    // page write wrap, A8 = 1
    base_wr = n_wr;
    begin_txn(); xfer(8'h0A, rx); xfer(8'h3E, rx);
    xfer(8'h11, rx); xfer(8'h22, rx); xfer(8'h33, rx); end_txn();
    chk("R4 write count", n_wr - base_wr, 3);
    chk("R4 addr 0", cap_a[base_wr], 9'h13E);
    chk("R4 addr 1", cap_a[base_wr+1], 9'h13F);
    chk("R4 addr wrap", cap_a[base_wr+2], 9'h130);
    chk("R4 data wrap", cap_d[base_wr+2], 8'h33);

    // read refused while busy
    busy = 1; oe_any = 0;
    begin_txn(); xfer(8'h03, rx); xfer(8'h20, rx); xfer(8'hFF, rx); xfer(8'hFF, rx); end_txn();
    chk("R10 no drive when busy", oe_any, 0);
    busy = 0;

    // unknown opcode then a set-enable byte
    base_wren = n_wren; base_wr = n_wr;
    begin_txn(); xfer(8'h5A, rx); xfer(8'h06, rx); xfer(8'h02, rx); end_txn();
    chk("R11 unknown opcode ignored", (n_wren - base_wren) + (n_wr - base_wr), 0);

    // pause mid-read with clock activity during the pause
    begin_txn(); xfer(8'h03, rx); xfer(8'h40, rx);
    got = 0;
    for (int i = 7; i >= 5; i--) begin bit_xfer(1'b0, r); got[i] = r; end
    #(HALF/2); hold_n = 0; #HALF;
    chk("R9 oe off while paused", miso_oe, 0);
    for (int t = 0; t < 3; t++) begin mosi = ~mosi; sck = 1; #HALF; sck = 0; #HALF; end
    hold_n = 1; #HALF;
    for (int i = 4; i >= 0; i--) begin bit_xfer(1'b0, r); got[i] = r; end
    chk("R8 read resumes at same bit", got, memval(9'h040));
    xfer(8'hFF, rx);
    chk("R8 next byte after pause", rx, memval(9'h041));
    end_txn();

    // pause mid-write with noisy data during the pause
    base_wr = n_wr;
    begin_txn(); xfer(8'h02, rx); xfer(8'h50, rx);
    for (int i = 7; i >= 4; i--) bit_xfer(1'((8'hC6 >> i) & 1), r);
    #(HALF/2); hold_n = 0; #HALF;
    for (int t = 0; t < 3; t++) begin mosi = 1; sck = 1; #HALF; sck = 0; mosi = 0; #HALF; end
    hold_n = 1; #HALF;
    for (int i = 3; i >= 0; i--) bit_xfer(1'((8'hC6 >> i) & 1), r);
    end_txn();
    chk("R8 write byte count", n_wr - base_wr, 1);
    chk("R8 write data intact", cap_d[base_wr], 8'hC6);
    chk("R8 write addr", cap_a[base_wr], 9'h050);

    // pause pulse confined to a clock-high phase: no pause taken
    begin_txn(); xfer(8'h03, rx); xfer(8'hA0, rx);
    got = 0;
    for (int i = 7; i >= 0; i--) begin
      mosi = 0; #HALF; got[i] = miso; sck = 1;
      if (i == 5) begin #20; hold_n = 0; #40; hold_n = 1; #40; end
      else #HALF;
      sck = 0;
    end
    chk("R8 high-phase pulse ignored", got, memval(9'h0A0));
    xfer(8'hFF, rx);
    chk("R3 follow-on byte", rx, memval(9'h0A1));
    end_txn();
    chk("R12 release events seen", n_csr > 10, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule